// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Block

This block is a 32-bit general-purpose I/O peripheral on a simple synchronous register bus that carries whole 32-bit words. It keeps three registers: a pin level register, a direction register (a 1 bit makes that pin an output) and a spare read/write scratch register. Software raises pins through a set address and lowers them through a clear address. Each such write acts on the full data word, but only if at least one of the written bits falls on a pin that is configured as an output. If none does, the write is dropped. The update is not masked bit by bit, so a written bit on an input pin also changes once the write passes the test.

The level register drives the output pins. Each pin's output enable is its direction bit. Three addresses for edge configuration and edge status are decoded, but writes to them do nothing and reads return zero. Nine interrupt lines exist: eight serve the low-numbered pins and one is shared by the remaining pins. All nine are held low. A request is a single cycle that carries an address, a write enable and write data. Read data is registered and is valid on the cycle after the request.

Top module: `gpio_regblk`

## Requirements
- R1: After reset the level, direction and scratch registers are all zero. The pin outputs, output enables, read data and interrupt lines are zero.
- R2: A read of offset 0x00 returns the level register and a read of 0x04 returns the direction register. Read data appears on `rd_data` one cycle after the request and stays there until the next read request.
- R3: A write to 0x04 loads the direction register. `pin_oe[i]` equals direction bit i.
- R4: A write to 0x08 ORs the full data word into the level register when (data AND direction) is nonzero. Otherwise the level register is unchanged.
- R5: A write to 0x0C clears the written bits (level AND NOT data) under the same nonzero-overlap rule. Otherwise the level register is unchanged.
- R6: The overlap test uses the whole data word and is not a per-bit mask. Written bits on input pins also change when at least one written bit is on an output pin.
- R7: Offset 0x20 is a read/write 32-bit scratch register that resets to zero.
- R8: Writes to 0x10, 0x14, 0x18 and to any undecoded offset change no register. Reads of every offset other than 0x00, 0x04 and 0x20 return zero.
- R9: `pin_out` always equals the level register.
- R10: The nine interrupt outputs `irq` are never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Bus request valid for this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte offset of the word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| pin_out | output | 32 | Pin drive values |
| pin_oe | output | 32 | Pin output enables |
| irq | output | 9 | Interrupt lines, held low |

## Verification
The hardest case to reach is the gating test at its edge. A set or clear whose data touches exactly one output pin must apply all of its bits, including bits on input pins. The same write shifted by one bit onto input pins only must be dropped entirely. The stimulus first sets the direction register to a sparse pattern. It then issues set and clear writes with single-bit overlap, zero overlap and mixed data, and reads the level register back after each write. It also checks the pins directly.

// File: rtl/gpio_regblk_pkg.sv
package gpio_regblk_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int IRQ_N  = 9;

    typedef enum logic [ADDR_W-1:0] {
        OFS_LEVEL   = 8'h00,
        OFS_DIR     = 8'h04,
        OFS_SET     = 8'h08,
        OFS_CLR     = 8'h0C,
        OFS_RISE    = 8'h10,
        OFS_FALL    = 8'h14,
        OFS_EDGE_ST = 8'h18,
        OFS_SCRATCH = 8'h20
    } gpio_ofs_e;

    typedef struct packed {
        logic level_rd;
        logic dir_rd;
        logic scr_rd;
        logic dir_wr;
        logic set_wr;
        logic clr_wr;
        logic scr_wr;
    } gpio_dec_t;

    function automatic logic overlap(input logic [DATA_W-1:0] d,
                                     input logic [DATA_W-1:0] dir);
        return |(d & dir);
    endfunction
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_regblk_pkg::*;
(
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output gpio_dec_t         dec
);
    always_comb begin
        dec = '0;
        if (req) begin
            unique case (addr)
                OFS_LEVEL:   dec.level_rd = !we;
                OFS_DIR:     begin dec.dir_rd = !we; dec.dir_wr = we; end
                OFS_SET:     dec.set_wr = we;
                OFS_CLR:     dec.clr_wr = we;
                OFS_SCRATCH: begin dec.scr_rd = !we; dec.scr_wr = we; end
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_level_reg.sv
module gpio_level_reg
    import gpio_regblk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_wr,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] dir_q,
    output logic [DATA_W-1:0] level_q
);
    logic gate_ok;
    assign gate_ok = overlap(wdata, dir_q);

    always_ff @(posedge clk) begin
        if (rst)
            level_q <= '0;
        else if (set_wr && gate_ok)
            level_q <= level_q | wdata;
        else if (clr_wr && gate_ok)
            level_q <= level_q & ~wdata;
    end

    p_set_dropped_r4: assert property (@(posedge clk) disable iff (rst)
        (set_wr && ((wdata & dir_q) == '0)) |=> $stable(level_q));
    p_clr_dropped_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && ((wdata & dir_q) == '0)) |=> $stable(level_q));
    p_set_whole_word_r6: assert property (@(posedge clk) disable iff (rst)
        (set_wr && ((wdata & dir_q) != '0)) |=> ((level_q & $past(wdata)) == $past(wdata)));
    p_clr_whole_word_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && ((wdata & dir_q) != '0)) |=> ((level_q & $past(wdata)) == '0));
endmodule

// File: rtl/gpio_regblk.sv
module gpio_regblk
    import gpio_regblk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [7:0]        addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic [31:0]       pin_out,
    output logic [31:0]       pin_oe,
    output logic [8:0]        irq
);
    gpio_dec_t         dec;
    logic [DATA_W-1:0] dir_q, level_q, scr_q, rd_next;

    gpio_addr_dec u_dec (.req(req), .we(we), .addr(addr), .dec(dec));

    gpio_level_reg u_level (
        .clk(clk), .rst(rst), .set_wr(dec.set_wr), .clr_wr(dec.clr_wr),
        .wdata(wr_data), .dir_q(dir_q), .level_q(level_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            scr_q <= '0;
        end else begin
            if (dec.dir_wr) dir_q <= wr_data;
            if (dec.scr_wr) scr_q <= wr_data;
        end
    end

    always_comb begin
        rd_next = '0;
        if (dec.level_rd) rd_next = level_q;
        if (dec.dir_rd)   rd_next = dir_q;
        if (dec.scr_rd)   rd_next = scr_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (req && !we)
            rd_data <= rd_next;
    end

    assign pin_out = level_q;
    assign pin_oe  = dir_q;
    assign irq     = '0;

    p_irq_quiet_r10: assert property (@(posedge clk) disable iff (rst) irq == '0);
    p_pins_follow_r9: assert property (@(posedge clk) disable iff (rst) pin_out == level_q);
    p_dir_load_r3: assert property (@(posedge clk) disable iff (rst)
        (req && we && addr == 8'h04) |=> (pin_oe == $past(wr_data)));
    p_ignored_wr_r8: assert property (@(posedge clk) disable iff (rst)
        (req && we && (addr == 8'h10 || addr == 8'h14 || addr == 8'h18))
        |=> ($stable(pin_out) && $stable(pin_oe)));
    p_bad_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (req && !we && addr != 8'h00 && addr != 8'h04 && addr != 8'h20) |=> rd_data == '0);
endmodule

// File: tb/gpio_regblk_test.sv
module gpio_regblk_test;
    logic clk = 0, rst = 1, req = 0, we = 0;
    logic [7:0]  addr = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] rd_data, pin_out, pin_oe;
    logic [8:0]  irq;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    gpio_regblk uut (.clk(clk), .rst(rst), .req(req), .we(we), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); req = 1; we = 1; addr = a; wr_data = d;
        @(negedge clk); req = 0; we = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); req = 1; we = 0; addr = a;
        @(negedge clk); req = 0; d = rd_data;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 pin_out", pin_out, 0);
        check("R1 pin_oe", pin_oe, 0);
        check("R1 rd_data", rd_data, 0);
        check("R1 irq", {23'd0, irq}, 0);
        rd(8'h20, v); check("R1 scratch", v, 0);
        rd(8'h00, v); check("R1 level", v, 0);
    endtask

    task automatic t_dir;
        logic [31:0] v;
        wr(8'h04, 32'h0000_00F1);
        check("R3 pin_oe", pin_oe, 32'h0000_00F1);
        rd(8'h04, v); check("R2 dir read", v, 32'h0000_00F1);
        check("R2 rd_data hold", rd_data, 32'h0000_00F1);
    endtask

    task automatic t_set_clr;
        logic [31:0] v;
        wr(8'h08, 32'h0000_0F00);           // no overlap with 0xF1
        rd(8'h00, v); check("R4 set dropped", v, 0);
        wr(8'h08, 32'h0000_0303);           // bit0 overlaps
        rd(8'h00, v); check("R6 set whole word", v, 32'h0000_0303);
        check("R9 pin_out", pin_out, 32'h0000_0303);
        wr(8'h0C, 32'h0000_0302);           // no overlap
        rd(8'h00, v); check("R5 clr dropped", v, 32'h0000_0303);
        wr(8'h0C, 32'h0000_0201);           // bit0 overlaps
        rd(8'h00, v); check("R6 clr whole word", v, 32'h0000_0102);
        wr(8'h0C, 32'h0000_0103);
        rd(8'h00, v); check("R5 clr", v, 0);
    endtask

    task automatic t_same_cycle;
        logic [31:0] v;
        // dir write and set in successive cycles: the set must see the new dir
        wr(8'h04, 32'h8000_0000);
        wr(8'h08, 32'h8000_0001);
        rd(8'h00, v); check("R4 set new dir", v, 32'h8000_0001);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R5 clr all", v, 0);
    endtask

    task automatic t_scratch_ignored;
        logic [31:0] v;
        wr(8'h20, 32'hDEAD_BEEF);
        rd(8'h20, v); check("R7 scratch", v, 32'hDEAD_BEEF);
        wr(8'h08, 32'h0000_5A5A | 32'h8000_0000);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R8 level kept", v, 32'h8000_5A5A);
        rd(8'h04, v); check("R8 dir kept", v, 32'h8000_0000);
        rd(8'h20, v); check("R8 scratch kept", v, 32'hDEAD_BEEF);
        for (int a = 8; a <= 8'h1C; a += 4) begin
            rd(a[7:0], v); check("R8 undecoded read", v, 0);
        end
        check("R10 irq", {23'd0, irq}, 0);
    endtask

    initial begin
        #200_000;
        fails++; checks++;
        $display("FAIL watchdog expected=done actual=hung");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_dir();
        t_set_clr();
        t_same_cycle();
        t_scratch_ignored();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule